// File: doc/BRIEF.md
# SDH Drop Bus Input Checker

This block terminates the receive side of a byte-wide SDH/SONET drop bus that carries an STM-1 or STS-3c stream. On each falling edge of the drop clock it takes in the data byte, the odd parity bit, the payload-window indicator and the shared timing pulse. An optional separate frame-start pulse is merged into the shared pulse. The merged pulse is then split into a frame-start (C1) strobe and a payload-start (J1) strobe, based on the payload indicator.

The block also checks the bus parity. Which bus fields the parity covers depends on two controls: a pointer-tracking mode and a data-only override. A registered error pulse and a sticky error flag report parity failures. A merged pulse that stays high for more than one capture is flagged as a width error. A monitor in a free-running reference-clock domain raises a loss-of-clock flag when the drop clock stops toggling.

The downstream logic uses the delayed byte, the delayed payload indicator and the two strobes as its aligned receive stream. Software controls the two sticky flags through write-one-to-clear strobes.

Top module: `dbus_drop_checker`

## Requirements
- R1: All drop bus inputs are registered on the falling edge of `drop_clk`. `rx_data` (bit 7 is the first bit on the line) and `rx_spe` reproduce the bus byte and payload indicator two falling edges after they were presented.
- R2: The merged timing pulse is the OR of `bus_sync` and `aux_c1`. A pulse on either input produces the same strobe.
- R3: With tracking off, a merged pulse that rises while `bus_spe` is 0 gives a one-cycle `c1_stb`. One that rises while `bus_spe` is 1 gives a one-cycle `j1_stb`. Each strobe appears two falling edges after the pulse was presented.
- R4: With `track_en` = 1, `bus_spe` is ignored for decoding. Every merged pulse yields `c1_stb`, and `j1_stb` stays 0.
- R5: Parity is odd. With `track_en` = 0 and `par_data_only` = 0, it covers the 8 data bits, `bus_spe`, `bus_sync` and `bus_par`. A mismatch gives a one-cycle `par_err` two falling edges later.
- R6: With `track_en` = 1 and `par_data_only` = 0, parity covers the data bits, `bus_sync` and `bus_par` only, so `bus_spe` has no effect on it.
- R7: With `par_data_only` = 1, parity covers only the data bits and `bus_par`, whatever `track_en` is.
- R8: `par_sticky` is set by any parity error. It stays set until a falling edge with `clr_par` = 1 clears it.
- R9: If the merged pulse is high on two consecutive captures, only one strobe is made, and `width_err` is set one falling edge after that strobe. `width_err` stays set until a falling edge with `clr_width` = 1.
- R10: `los` rises once 16 consecutive `ref_clk` cycles see no drop-clock edge. It falls again within a few reference cycles after the drop clock resumes.
- R11: While reset is held, all strobes, error flags, `rx_data`, `rx_spe` and `los` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drop_clk | input | 1 | Drop bus clock; inputs sampled on its falling edge |
| drop_rst | input | 1 | Synchronous active-high reset, drop domain |
| ref_clk | input | 1 | Free-running reference clock for the clock monitor |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| bus_data | input | 8 | Drop bus byte, bit 7 first on the line |
| bus_par | input | 1 | Odd parity bit from the bus |
| bus_spe | input | 1 | Payload-window indicator |
| bus_sync | input | 1 | Shared C1/J1 timing pulse |
| aux_c1 | input | 1 | Optional separate C1 pulse, ORed into the shared pulse |
| track_en | input | 1 | Pointer-tracking mode select |
| par_data_only | input | 1 | Restrict parity to the data byte |
| clr_par | input | 1 | Write-one-to-clear for `par_sticky` |
| clr_width | input | 1 | Write-one-to-clear for `width_err` |
| rx_data | output | 8 | Captured byte, aligned with the strobes |
| rx_spe | output | 1 | Captured payload indicator, aligned with the strobes |
| c1_stb | output | 1 | Frame-start strobe |
| j1_stb | output | 1 | Payload-start strobe |
| par_err | output | 1 | One-cycle parity error pulse |
| par_sticky | output | 1 | Sticky parity error flag |
| width_err | output | 1 | Sticky pulse-width error flag |
| los | output | 1 | Loss of drop clock flag (reference domain) |

## Verification
Data, payload indicator, strobes and the parity pulse all come from a two-stage falling-edge pipeline. The bench drives each vector just after a rising edge, holds idle bus values for the following cycle, and samples one more rising edge later, after both falling edges have passed. The width flag comes one falling edge after its strobe, and a clear shows one falling edge after the clear strobe, so those checks sample one more rising edge later. The loss flag is checked only after 40 reference cycles with the drop clock stopped, and again after four drop cycles once it resumes. This keeps the check clear of the synchronizer latency.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    PCOV_FULL  = 2'd0,
    PCOV_TRACK = 2'd1,
    PCOV_DATA  = 2'd2
  } pcov_e;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             par;
    logic             spe;
    logic             pin_pulse;
    logic             merged;
  } cap_s;

  function automatic pcov_e pick_cov(input logic track, input logic data_only);
    if (data_only)  return PCOV_DATA;
    else if (track) return PCOV_TRACK;
    else            return PCOV_FULL;
  endfunction
endpackage

// File: rtl/dbus_capture.sv
module dbus_capture
  import dbus_pkg::*;
(
  input  logic             drop_clk,
  input  logic             drop_rst,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_par,
  input  logic             bus_spe,
  input  logic             bus_sync,
  input  logic             aux_c1,
  output cap_s             cap
);
  always_ff @(negedge drop_clk) begin
    if (drop_rst) begin
      cap <= '0;
    end else begin
      cap.data      <= bus_data;
      cap.par       <= bus_par;
      cap.spe       <= bus_spe;
      cap.pin_pulse <= bus_sync;
      cap.merged    <= bus_sync | aux_c1;
    end
  end
endmodule

// File: rtl/dbus_pulse_decode.sv
module dbus_pulse_decode (
  input  logic drop_clk,
  input  logic drop_rst,
  input  logic merged,
  input  logic spe,
  input  logic track_en,
  input  logic clr_width,
  output logic c1_stb,
  output logic j1_stb,
  output logic width_err
);
  logic merged_q;
  logic lead;

  assign lead = merged & ~merged_q;

  always_ff @(negedge drop_clk) begin
    if (drop_rst) begin
      merged_q  <= 1'b0;
      c1_stb    <= 1'b0;
      j1_stb    <= 1'b0;
      width_err <= 1'b0;
    end else begin
      merged_q <= merged;
      c1_stb   <= lead & (track_en | ~spe);
      j1_stb   <= lead & ~track_en & spe;
      if (merged & merged_q) width_err <= 1'b1;
      else if (clr_width)    width_err <= 1'b0;
    end
  end
endmodule

// File: rtl/dbus_parity_chk.sv
module dbus_parity_chk
  import dbus_pkg::*;
(
  input  logic             drop_clk,
  input  logic             drop_rst,
  input  logic [BUS_W-1:0] data,
  input  logic             par,
  input  logic             spe,
  input  logic             pin_pulse,
  input  logic             track_en,
  input  logic             par_data_only,
  input  logic             clr_par,
  output logic             par_err,
  output logic             par_sticky
);
  pcov_e mode;
  logic  sum;

  assign mode = pick_cov(track_en, par_data_only);

  always_comb begin
    case (mode)
      PCOV_DATA:  sum = (^data) ^ par;
      PCOV_TRACK: sum = (^data) ^ par ^ pin_pulse;
      default:    sum = (^data) ^ par ^ pin_pulse ^ spe;
    endcase
  end

  always_ff @(negedge drop_clk) begin
    if (drop_rst) begin
      par_err    <= 1'b0;
      par_sticky <= 1'b0;
    end else begin
      par_err <= ~sum;
      if (~sum)         par_sticky <= 1'b1;
      else if (clr_par) par_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/dbus_clk_mon.sv
module dbus_clk_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int LOS_CYCLES  = 16
) (
  input  logic drop_clk,
  input  logic drop_rst,
  input  logic ref_clk,
  input  logic ref_rst,
  output logic los
);
  localparam int CNT_W = $clog2(LOS_CYCLES + 1);

  logic             tog;
  logic             stg [SYNC_STAGES+1];
  logic [CNT_W-1:0] idle_cnt;
  logic             seen;

  always_ff @(negedge drop_clk) begin
    if (drop_rst) tog <= 1'b0;
    else          tog <= ~tog;
  end

  always_comb stg[0] = tog;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge ref_clk) begin
      if (ref_rst) stg[i+1] <= 1'b0;
      else         stg[i+1] <= stg[i];
    end
  end

  logic last_q;
  always_ff @(posedge ref_clk) begin
    if (ref_rst) last_q <= 1'b0;
    else         last_q <= stg[SYNC_STAGES];
  end

  assign seen = last_q ^ stg[SYNC_STAGES];

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      idle_cnt <= '0;
      los      <= 1'b0;
    end else if (seen) begin
      idle_cnt <= '0;
      los      <= 1'b0;
    end else if (idle_cnt == CNT_W'(LOS_CYCLES - 1)) begin
      los <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbus_drop_checker.sv
module dbus_drop_checker
  import dbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOS_CYCLES  = 16
) (
  input  logic             drop_clk,
  input  logic             drop_rst,
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_par,
  input  logic             bus_spe,
  input  logic             bus_sync,
  input  logic             aux_c1,
  input  logic             track_en,
  input  logic             par_data_only,
  input  logic             clr_par,
  input  logic             clr_width,
  output logic [BUS_W-1:0] rx_data,
  output logic             rx_spe,
  output logic             c1_stb,
  output logic             j1_stb,
  output logic             par_err,
  output logic             par_sticky,
  output logic             width_err,
  output logic             los
);
  cap_s cap;

  dbus_capture u_cap (
    .drop_clk (drop_clk),
    .drop_rst (drop_rst),
    .bus_data (bus_data),
    .bus_par  (bus_par),
    .bus_spe  (bus_spe),
    .bus_sync (bus_sync),
    .aux_c1   (aux_c1),
    .cap      (cap)
  );

  always_ff @(negedge drop_clk) begin
    if (drop_rst) begin
      rx_data <= '0;
      rx_spe  <= 1'b0;
    end else begin
      rx_data <= cap.data;
      rx_spe  <= cap.spe;
    end
  end

  dbus_pulse_decode u_dec (
    .drop_clk  (drop_clk),
    .drop_rst  (drop_rst),
    .merged    (cap.merged),
    .spe       (cap.spe),
    .track_en  (track_en),
    .clr_width (clr_width),
    .c1_stb    (c1_stb),
    .j1_stb    (j1_stb),
    .width_err (width_err)
  );

  dbus_parity_chk u_par (
    .drop_clk      (drop_clk),
    .drop_rst      (drop_rst),
    .data          (cap.data),
    .par           (cap.par),
    .spe           (cap.spe),
    .pin_pulse     (cap.pin_pulse),
    .track_en      (track_en),
    .par_data_only (par_data_only),
    .clr_par       (clr_par),
    .par_err       (par_err),
    .par_sticky    (par_sticky)
  );

  dbus_clk_mon #(
    .SYNC_STAGES (SYNC_STAGES),
    .LOS_CYCLES  (LOS_CYCLES)
  ) u_mon (
    .drop_clk (drop_clk),
    .drop_rst (drop_rst),
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .los      (los)
  );
endmodule

// File: rtl/dbus_drop_checker_sva.sv
module dbus_drop_checker_sva (
  input logic drop_clk,
  input logic drop_rst,
  input logic ref_clk,
  input logic ref_rst,
  input logic track_en,
  input logic clr_par,
  input logic c1_stb,
  input logic j1_stb,
  input logic par_err,
  input logic par_sticky,
  input logic los
);
  AST_STB_EXCLUSIVE: assert property (@(negedge drop_clk) disable iff (drop_rst)
    !(c1_stb && j1_stb)); // R3

  AST_C1_SINGLE: assert property (@(negedge drop_clk) disable iff (drop_rst)
    c1_stb |=> !c1_stb); // R9

  AST_J1_SINGLE: assert property (@(negedge drop_clk) disable iff (drop_rst)
    j1_stb |=> !j1_stb); // R9

  AST_TRACK_NO_J1: assert property (@(negedge drop_clk) disable iff (drop_rst)
    j1_stb |-> !$past(track_en)); // R4

  AST_STICKY_SET: assert property (@(negedge drop_clk) disable iff (drop_rst)
    $rose(par_sticky) |-> par_err); // R8

  AST_STICKY_HOLD: assert property (@(negedge drop_clk) disable iff (drop_rst)
    (par_sticky && !clr_par) |=> par_sticky); // R8

  AST_LOS_RESET: assert property (@(posedge ref_clk)
    ref_rst |=> !los); // R11
endmodule

bind dbus_drop_checker dbus_drop_checker_sva u_sva (
  .drop_clk   (drop_clk),
  .drop_rst   (drop_rst),
  .ref_clk    (ref_clk),
  .ref_rst    (ref_rst),
  .track_en   (track_en),
  .clr_par    (clr_par),
  .c1_stb     (c1_stb),
  .j1_stb     (j1_stb),
  .par_err    (par_err),
  .par_sticky (par_sticky),
  .los        (los)
);

// File: tb/tb_dbus_drop_checker.sv
module tb_dbus_drop_checker;
  logic       drop_clk = 1'b0;
  logic       ref_clk  = 1'b0;
  logic       drop_rst = 1'b1;
  logic       ref_rst  = 1'b1;
  logic       drop_run = 1'b1;
  logic [7:0] bus_data = '0;
  logic       bus_par  = 1'b1;
  logic       bus_spe  = 1'b0;
  logic       bus_sync = 1'b0;
  logic       aux_c1   = 1'b0;
  logic       track_en = 1'b0;
  logic       par_data_only = 1'b0;
  logic       clr_par  = 1'b0;
  logic       clr_width = 1'b0;
  logic [7:0] rx_data;
  logic       rx_spe, c1_stb, j1_stb, par_err, par_sticky, width_err, los;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dbus_drop_checker dut (
    .drop_clk (drop_clk), .drop_rst (drop_rst),
    .ref_clk (ref_clk), .ref_rst (ref_rst),
    .bus_data (bus_data), .bus_par (bus_par), .bus_spe (bus_spe),
    .bus_sync (bus_sync), .aux_c1 (aux_c1),
    .track_en (track_en), .par_data_only (par_data_only),
    .clr_par (clr_par), .clr_width (clr_width),
    .rx_data (rx_data), .rx_spe (rx_spe), .c1_stb (c1_stb), .j1_stb (j1_stb),
    .par_err (par_err), .par_sticky (par_sticky), .width_err (width_err),
    .los (los)
  );

  always #2 ref_clk = ~ref_clk;
  always begin
    #12;
    if (drop_run) drop_clk = ~drop_clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge drop_clk);
    #1;
  endtask

  task automatic idle();
    bus_data = '0; bus_spe = 1'b0; bus_sync = 1'b0; aux_c1 = 1'b0; bus_par = 1'b1;
  endtask

  // {data[7:0], spe, sync, aux, track, data_only, flip}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h7E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h55, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hF0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  initial begin : watchdog
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (4) step();
    // R11: reset state
    chk("R11 c1_stb", c1_stb, 0);
    chk("R11 j1_stb", j1_stb, 0);
    chk("R11 par_err", par_err, 0);
    chk("R11 flags", {par_sticky, width_err, los}, 0);
    chk("R11 rx_data", rx_data, 0);
    drop_rst = 1'b0; ref_rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [7:0] d;
      logic s, y, a, t, o, f, cov, ec1, ej1;
      {d, s, y, a, t, o, f} = VEC[i];
      // R5/R6/R7: coverage model
      if (o)      cov = ^d;
      else if (t) cov = (^d) ^ y;
      else        cov = (^d) ^ y ^ s;
      ec1 = (y | a) & (t | ~s);   // R2 R3 R4
      ej1 = (y | a) & ~t & s;
      track_en = t; par_data_only = o;
      bus_data = d; bus_spe = s; bus_sync = y; aux_c1 = a;
      bus_par = ~cov ^ f;
      step();
      idle();
      step();
      chk($sformatf("R3/R4 c1_stb vec%0d", i), c1_stb, ec1);
      chk($sformatf("R3/R4 j1_stb vec%0d", i), j1_stb, ej1);
      chk($sformatf("R5/R6/R7 par_err vec%0d", i), par_err, f);
      chk($sformatf("R1 rx_data vec%0d", i), {rx_data, rx_spe}, {d, s});
    end
    track_en = 1'b0; par_data_only = 1'b0;
    step();

    // R8: sticky holds, then clears on write-one
    chk("R8 sticky held", par_sticky, 1);
    chk("R8 par_err idle", par_err, 0);
    clr_par = 1'b1;
    step();
    clr_par = 1'b0;
    chk("R8 sticky cleared", par_sticky, 0);
    step();
    chk("R8 sticky stays clear", par_sticky, 0);

    // R9: two-cycle pulse on aux input
    aux_c1 = 1'b1;
    step();
    step();
    chk("R9 single strobe first", c1_stb, 1);
    chk("R9 no width yet", width_err, 0);
    idle();
    step();
    chk("R9 no second strobe", c1_stb, 0);
    chk("R9 width_err set", width_err, 1);
    step();
    chk("R9 width_err sticky", width_err, 1);
    clr_width = 1'b1;
    step();
    clr_width = 1'b0;
    chk("R9 width_err cleared", width_err, 0);

    // R10: loss of drop clock
    chk("R10 los idle", los, 0);
    drop_run = 1'b0;
    repeat (40) @(posedge ref_clk);
    #1;
    chk("R10 los raised", los, 1);
    drop_run = 1'b1;
    repeat (4) step();
    chk("R10 los cleared", los, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule